// File: doc/BRIEF.md
# Aperture Address Decoder

This block classifies every load or store address issued by a processor and names the one target that must service it. Four kinds of window are programmed through a small register-write port. The first is a fixed 2 MB register-space window at a movable base. The second is a memory window with a lower bound, an upper bound and a cacheability limit. The third is a peripheral window whose upper bound of zero stands for the top of the 32-bit space. The fourth is a set of three sub-windows inside the peripheral window, for two PCI regions and one expansion I/O region.

A request is accepted in one cycle and its routing decision appears one cycle later. The decision is a one-hot target select, a cacheability flag and a copy of the address and direction. An address that lands nowhere, or in the gaps of the peripheral window, is dropped quietly. Such addresses are normal here, because speculative loads can carry garbage addresses. A dropped read still completes with a fixed filler word, so the issuing side never waits and never faults.

Top module: `aperture_router`

## Requirements
- R1: After reset every bound register holds all ones, so only the register-space window at parameter RESET_BASE (default 0x1BE0_0000) decodes. Its 2 MB span goes to the register target and every other address is dropped. No output is valid until the first request.
- R2: The register-space window covers base <= addr < base + 2 MB, where base is the value of config register 0.
- R3: The memory window covers lo <= addr < hi, using config registers 1 and 2. Within it, out_cacheable is 1 exactly when addr < the cache limit in config register 3. out_cacheable is 0 for every other target.
- R4: The peripheral window covers lo <= addr < hi, using config registers 4 and 5. A value of 0 in register 5 means 2^32, and the comparison is made at 33 bits.
- R5: Inside the peripheral window, three sub-windows each cover lo <= addr < hi: PCI1 uses registers 6/7, PCI2 uses registers 8/9 and XIO uses registers 10/11. Where they overlap, PCI1 wins over PCI2 and PCI2 wins over XIO.
- R6: An address inside the peripheral window that hits no sub-window is routed to the drop target, with no error of any kind.
- R7: An address outside every window is routed to the drop target.
- R8: Where windows overlap, the register window takes precedence over the memory window, and the memory window takes precedence over the peripheral window.
- R9: A dropped read raises out_fill_valid with out_fill_data = 0xDEAD_BEEF in the response cycle. A dropped write, and any non-dropped access, leaves out_fill_valid at 0.
- R10: out_valid is high exactly one cycle after req_valid. In that cycle it carries the request's address in out_addr and its direction in out_write (1 = write).
- R11: A config write (cfg_we, with cfg_sel selecting the register) changes decoding for requests from the following cycle onward. A request in the same cycle as the write is decoded with the old value.
- R12: out_target is one-hot: bit 0 = register space, 1 = memory, 2 = PCI1, 3 = PCI2, 4 = XIO, 5 = drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 4 | Config register index (0..11) |
| cfg_wdata | input | 32 | Config write data |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Request address |
| out_valid | output | 1 | Routing decision valid |
| out_write | output | 1 | Direction of the routed request |
| out_addr | output | 32 | Address of the routed request |
| out_target | output | 6 | One-hot target select |
| out_cacheable | output | 1 | Memory access below the cache limit |
| out_fill_valid | output | 1 | Filler read data valid for a dropped read |
| out_fill_data | output | 32 | Filler read data |

## Verification
The hardest case to reach from the ports is a peripheral window that ends at the top of the address space. To reach it, the stimulus programs a zero upper bound and places the XIO sub-window at the last addresses, then sends a request at 0xFFFF_FFF0. That request routes to XIO only when the zero bound is widened to 2^32. The stimulus then rewrites the bound to a finite value and resends the same addresses, which must now be dropped. A config write is also issued in the very cycle of a request that straddles the old and new memory bounds, which exposes whether the decoder uses the bounds held when the request was accepted.

// File: rtl/aperture_pkg.sv
package aperture_pkg;
  localparam int AW       = 32;
  localparam int NUM_CFG  = 12;
  localparam int CFG_SELW = $clog2(NUM_CFG);
  localparam int NUM_SUB  = 3;

  // target select bit positions
  localparam int TGT_REG  = 0;
  localparam int TGT_MEM  = 1;
  localparam int TGT_PCI1 = 2;
  localparam int TGT_PCI2 = 3;
  localparam int TGT_XIO  = 4;
  localparam int TGT_DROP = 5;
  localparam int NUM_TGT  = 6;

  // config register indices
  localparam int CFG_REG_BASE = 0;
  localparam int CFG_MEM_LO   = 1;
  localparam int CFG_MEM_HI   = 2;
  localparam int CFG_MEM_CLIM = 3;
  localparam int CFG_PER_LO   = 4;
  localparam int CFG_PER_HI   = 5;
  localparam int CFG_SUB_BASE = 6;

  localparam logic [AW-1:0] FILL_WORD = 32'hDEAD_BEEF;
endpackage

// File: rtl/aperture_cfg_regs.sv
module aperture_cfg_regs
  import aperture_pkg::*;
#(
  parameter int            NREG       = NUM_CFG,
  parameter int            W          = AW,
  parameter logic [W-1:0]  RESET_BASE = 32'h1BE0_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(NREG)-1:0]       sel,
  input  logic [W-1:0]                  wdata,
  output logic [NREG-1:0][W-1:0]        regs
);
  localparam int SW = $clog2(NREG);

  logic [NREG-1:0]         wr_en;
  logic [NREG-1:0][W-1:0]  regs_d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [W-1:0] RSTV = (i == CFG_REG_BASE) ? RESET_BASE : {W{1'b1}};

    always_comb begin
      wr_en[i]  = we && (sel == SW'(i));
      regs_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= RSTV;
      end else if (wr_en[i]) begin
        regs[i] <= regs_d[i];
      end
    end
  end

  AST_CFG_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SW'(CFG_REG_BASE)) |=> (regs[CFG_REG_BASE] == $past(wdata))); // R11
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs)); // R11
endmodule

// File: rtl/aperture_window_match.sv
module aperture_window_match
  import aperture_pkg::*;
#(
  parameter int W           = AW,
  parameter bit ZERO_IS_TOP = 1'b0
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] lo,
  input  logic [W:0]   hi_ext,
  output logic         hit
);
  logic [W:0] hi_eff;
  logic [W:0] addr_x;
  logic [W:0] lo_x;

  if (ZERO_IS_TOP) begin : g_wide
    always_comb begin
      if (hi_ext[W-1:0] == '0) hi_eff = {1'b1, {W{1'b0}}};
      else                     hi_eff = hi_ext;
    end
  end else begin : g_plain
    always_comb hi_eff = hi_ext;
  end

  always_comb begin
    addr_x = {1'b0, addr};
    lo_x   = {1'b0, lo};
    hit    = (addr_x >= lo_x) && (addr_x < hi_eff);
  end
endmodule

// File: rtl/aperture_route_stage.sv
module aperture_route_stage
  import aperture_pkg::*;
#(
  parameter int W    = AW,
  parameter int NSUB = NUM_SUB,
  parameter int NT   = NUM_TGT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [W-1:0]    req_addr,
  input  logic            reg_hit,
  input  logic            mem_hit,
  input  logic            below_clim,
  input  logic            per_hit,
  input  logic [NSUB-1:0] sub_hit,
  output logic            out_valid,
  output logic            out_write,
  output logic [W-1:0]    out_addr,
  output logic [NT-1:0]   out_target,
  output logic            out_cacheable,
  output logic            out_fill_valid,
  output logic [W-1:0]    out_fill_data
);
  logic [NT-1:0] tgt_d;
  logic          cache_d;
  logic          fill_d;
  logic [W-1:0]  fill_data_d;

  always_comb begin
    tgt_d   = '0;
    cache_d = 1'b0;
    if (reg_hit) begin
      tgt_d[TGT_REG] = 1'b1;
    end else if (mem_hit) begin
      tgt_d[TGT_MEM] = 1'b1;
      cache_d        = below_clim;
    end else if (per_hit && sub_hit[0]) begin
      tgt_d[TGT_PCI1] = 1'b1;
    end else if (per_hit && sub_hit[1]) begin
      tgt_d[TGT_PCI2] = 1'b1;
    end else if (per_hit && sub_hit[2]) begin
      tgt_d[TGT_XIO] = 1'b1;
    end else begin
      tgt_d[TGT_DROP] = 1'b1;
    end
    fill_d      = tgt_d[TGT_DROP] && !req_write;
    fill_data_d = fill_d ? FILL_WORD : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_write      <= 1'b0;
      out_addr       <= '0;
      out_target     <= '0;
      out_cacheable  <= 1'b0;
      out_fill_valid <= 1'b0;
      out_fill_data  <= '0;
    end else if (req_valid) begin
      out_write      <= req_write;
      out_addr       <= req_addr;
      out_target     <= tgt_d;
      out_cacheable  <= cache_d;
      out_fill_valid <= fill_d;
      out_fill_data  <= fill_data_d;
    end else begin
      out_fill_valid <= 1'b0;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_target) == 1)); // R12
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R10
  AST_FILL_ONLY_DROP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    out_fill_valid |-> (out_valid && out_target[TGT_DROP] && !out_write)); // R9
  AST_DROP_READ_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_target[TGT_DROP] && !out_write) |-> (out_fill_valid && out_fill_data == FILL_WORD)); // R9
  AST_CACHE_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_cacheable |-> out_target[TGT_MEM]); // R3
  AST_REG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && reg_hit) |=> out_target[TGT_REG]); // R8
  AST_SUB_NEEDS_PER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !per_hit && !reg_hit && !mem_hit) |=> out_target[TGT_DROP]); // R6
endmodule

// File: rtl/aperture_router.sv
module aperture_router
  import aperture_pkg::*;
#(
  parameter logic [31:0] RESET_BASE = 32'h1BE0_0000,
  parameter int          REG_SPAN_LOG2 = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  output logic        out_valid,
  output logic        out_write,
  output logic [31:0] out_addr,
  output logic [5:0]  out_target,
  output logic        out_cacheable,
  output logic        out_fill_valid,
  output logic [31:0] out_fill_data
);
  localparam logic [AW:0] REG_SPAN = (AW+1)'(1) << REG_SPAN_LOG2;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_CFG-1:0][AW-1:0] cfg;

  aperture_cfg_regs #(
    .NREG       (NUM_CFG),
    .W          (AW),
    .RESET_BASE (RESET_BASE)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .regs  (cfg)
  );

  logic          reg_hit, mem_hit, below_clim, per_hit;
  logic [NUM_SUB-1:0] sub_hit;
  logic [AW:0]   reg_hi;

  assign reg_hi = {1'b0, cfg[CFG_REG_BASE]} + REG_SPAN;

  aperture_window_match #(.W(AW), .ZERO_IS_TOP(1'b0)) u_reg_win (
    .addr (req_addr), .lo (cfg[CFG_REG_BASE]), .hi_ext (reg_hi), .hit (reg_hit)
  );

  aperture_window_match #(.W(AW), .ZERO_IS_TOP(1'b0)) u_mem_win (
    .addr (req_addr), .lo (cfg[CFG_MEM_LO]), .hi_ext ({1'b0, cfg[CFG_MEM_HI]}), .hit (mem_hit)
  );

  aperture_window_match #(.W(AW), .ZERO_IS_TOP(1'b0)) u_clim (
    .addr (req_addr), .lo ('0), .hi_ext ({1'b0, cfg[CFG_MEM_CLIM]}), .hit (below_clim)
  );

  aperture_window_match #(.W(AW), .ZERO_IS_TOP(1'b1)) u_per_win (
    .addr (req_addr), .lo (cfg[CFG_PER_LO]), .hi_ext ({1'b0, cfg[CFG_PER_HI]}), .hit (per_hit)
  );

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    aperture_window_match #(.W(AW), .ZERO_IS_TOP(1'b0)) u_sub_win (
      .addr   (req_addr),
      .lo     (cfg[CFG_SUB_BASE + 2*s]),
      .hi_ext ({1'b0, cfg[CFG_SUB_BASE + 2*s + 1]}),
      .hit    (sub_hit[s])
    );
  end

  aperture_route_stage #(.W(AW), .NSUB(NUM_SUB), .NT(NUM_TGT)) u_route (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .reg_hit        (reg_hit),
    .mem_hit        (mem_hit),
    .below_clim     (below_clim),
    .per_hit        (per_hit),
    .sub_hit        (sub_hit),
    .out_valid      (out_valid),
    .out_write      (out_write),
    .out_addr       (out_addr),
    .out_target     (out_target),
    .out_cacheable  (out_cacheable),
    .out_fill_valid (out_fill_valid),
    .out_fill_data  (out_fill_data)
  );

  AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> (out_addr == $past(req_addr) && out_write == $past(req_write))); // R10
  AST_WIDE_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && cfg[CFG_PER_HI] == '0 && req_addr >= cfg[CFG_PER_LO]) |-> per_hit); // R4
endmodule

// File: tb/aperture_router_bench.sv
module aperture_router_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_addr;
  logic        out_valid, out_write, out_cacheable, out_fill_valid;
  logic [31:0] out_addr, out_fill_data;
  logic [5:0]  out_target;

  localparam logic [5:0] T_REG  = 6'b000001;
  localparam logic [5:0] T_MEM  = 6'b000010;
  localparam logic [5:0] T_PCI1 = 6'b000100;
  localparam logic [5:0] T_PCI2 = 6'b001000;
  localparam logic [5:0] T_XIO  = 6'b010000;
  localparam logic [5:0] T_DROP = 6'b100000;

  typedef struct {
    logic [31:0] addr;
    logic        wr;
    logic [5:0]  tgt;
    logic        cache;
    logic        fill;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  aperture_router u_aperture_router (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
    .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
    .out_valid (out_valid), .out_write (out_write), .out_addr (out_addr),
    .out_target (out_target), .out_cacheable (out_cacheable),
    .out_fill_valid (out_fill_valid), .out_fill_data (out_fill_data)
  );

  // driver: called at a falling edge, returns at the next one
  task automatic send(input logic [31:0] a, input logic w, input logic [5:0] t,
                      input logic c, input string tag);
    exp_t e;
    e.addr = a; e.wr = w; e.tgt = t; e.cache = c;
    e.fill = (t == T_DROP) && !w; // R9
    e.tag = tag;
    req_valid = 1'b1; req_write = w; req_addr = a;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input int idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10: unexpected response addr=%h, expected none", out_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_addr !== e.addr || out_write !== e.wr || out_target !== e.tgt ||
            out_cacheable !== e.cache || out_fill_valid !== e.fill ||
            (e.fill && out_fill_data !== 32'hDEAD_BEEF)) begin
          n_bad++;
          $display("FAIL %s: got addr=%h wr=%b tgt=%b c=%b fill=%b data=%h, expected addr=%h wr=%b tgt=%b c=%b fill=%b",
                   e.tag, out_addr, out_write, out_target, out_cacheable, out_fill_valid,
                   out_fill_data, e.addr, e.wr, e.tgt, e.cache, e.fill);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    n_cmp++; // R1 reset state of outputs
    if (out_valid !== 1'b0 || out_fill_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: out_valid=%b fill=%b, expected 0 0", out_valid, out_fill_valid);
    end

    // R1 / R2 / R7: only the register window decodes after reset
    send(32'h1BE0_0000, 1'b0, T_REG,  1'b0, "R1");
    send(32'h1BFF_FFFC, 1'b1, T_REG,  1'b0, "R2");
    send(32'h1C00_0000, 1'b0, T_DROP, 1'b0, "R2");
    send(32'h0000_1000, 1'b0, T_DROP, 1'b0, "R7");
    send(32'h8000_0000, 1'b1, T_DROP, 1'b0, "R9");

    // R3: memory window and cache limit
    cfg(1, 32'h0000_0000);
    cfg(2, 32'h1000_0000);
    cfg(3, 32'h0800_0000);
    send(32'h0000_0000, 1'b0, T_MEM,  1'b1, "R3");
    send(32'h07FF_FFFC, 1'b0, T_MEM,  1'b1, "R3");
    send(32'h0800_0000, 1'b0, T_MEM,  1'b0, "R3");
    send(32'h0FFF_FFFC, 1'b1, T_MEM,  1'b0, "R3");
    send(32'h1000_0000, 1'b0, T_DROP, 1'b0, "R7");

    // R11: write and request in the same cycle
    cfg_we = 1'b1; cfg_sel = 4'd2; cfg_wdata = 32'h2000_0000;
    send(32'h1800_0000, 1'b0, T_DROP, 1'b0, "R11");
    cfg_we = 1'b0;
    send(32'h1800_0000, 1'b0, T_MEM,  1'b0, "R11");
    send(32'h1BE0_0000, 1'b0, T_REG,  1'b0, "R8");

    // peripheral window with zero upper bound and sub-windows
    cfg(4,  32'hE000_0000);
    cfg(5,  32'h0000_0000);
    cfg(6,  32'hE000_0000); cfg(7,  32'hE800_0000);
    cfg(8,  32'hF000_0000); cfg(9,  32'hF800_0000);
    cfg(10, 32'hFE00_0000); cfg(11, 32'hFFFF_FFFF);
    send(32'hE000_0000, 1'b0, T_PCI1, 1'b0, "R5");
    send(32'hE7FF_FFFC, 1'b1, T_PCI1, 1'b0, "R5");
    send(32'hF000_0000, 1'b0, T_PCI2, 1'b0, "R5");
    send(32'hFE00_0000, 1'b0, T_XIO,  1'b0, "R5");
    send(32'hFFFF_FFF0, 1'b0, T_XIO,  1'b0, "R4");
    send(32'hE800_0000, 1'b0, T_DROP, 1'b0, "R6");
    send(32'hFC00_0000, 1'b1, T_DROP, 1'b0, "R6");
    send(32'hFFFF_FFFF, 1'b0, T_DROP, 1'b0, "R6");

    // R5 sub-window precedence
    cfg(8, 32'hE400_0000);
    send(32'hE400_0000, 1'b0, T_PCI1, 1'b0, "R5");
    send(32'hE800_0000, 1'b0, T_PCI2, 1'b0, "R5");

    // R4: finite bound cuts the window
    cfg(5, 32'hF000_0000);
    send(32'hF000_0000, 1'b0, T_DROP, 1'b0, "R4");
    send(32'hFE00_0000, 1'b0, T_DROP, 1'b0, "R4");

    // R8: memory over peripheral
    cfg(4, 32'h1000_0000);
    cfg(6, 32'h1000_0000);
    send(32'h1100_0000, 1'b0, T_MEM,  1'b0, "R8");
    send(32'h2000_0000, 1'b0, T_PCI1, 1'b0, "R8");

    // R2: moved register window
    cfg(0, 32'h4000_0000);
    send(32'h401F_FFFC, 1'b0, T_REG,  1'b0, "R2");
    send(32'h4020_0000, 1'b0, T_PCI1, 1'b0, "R2");
    send(32'h1BE0_0000, 1'b1, T_MEM,  1'b0, "R2");

    repeat (3) @(negedge clk);
    n_cmp++; // R10 every request answered
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule